// File: doc/BRIEF.md
# Byte-Serial Dot-Product Stream Wrapper

This block sits in front of a two-term floating-point multiply-accumulate core. It takes a byte stream with a valid strobe and gathers a frame of five IEEE single-precision words: the first multiplicand pair `a0`, `a1`, then the second pair `b0`, `b1`, and last the seed `c0`. Each word arrives as four bytes. The block shows the assembled words to the core on parallel ports, fires a one-cycle start pulse, and waits a fixed number of cycles while the core works. It then captures the core's 32-bit result and returns it over the byte output, one byte per cycle, with an output strobe.

The block does no arithmetic and does not check the frame. A transaction takes 27 cycles when the input bytes come back to back. There are 20 cycles of load, 3 of compute and 4 of send. A new frame may start in the cycle right after the last result byte. The reset input is active low. It asserts asynchronously, and its release passes through a two-stage synchronizer, so the block leaves reset two rising edges after `rst_n` goes high.

Top module: `fpdot_byte_wrapper`

## Requirements
- R1: A frame is 20 accepted bytes. Accepted byte number k (0..19) lands in word k/4 at bits [(k%4)*8+7:(k%4)*8], so each word is little-endian. Words 0..4 appear on `op_a0`, `op_a1`, `op_b0`, `op_b1` and `op_c0`.
- R2: A byte is taken only in a cycle where `in_valid` is 1 during the load phase. Cycles with `in_valid` at 0 may fall anywhere in a frame and leave the frame unchanged.
- R3: `core_start` is 1 for exactly one cycle. That cycle is the one right after the rising edge that accepts the 20th byte.
- R4: The compute phase lasts exactly 3 cycles, counting from the `core_start` cycle. `core_result` is sampled at the rising edge that ends the third of these cycles.
- R5: The sampled result leaves on `out_byte` in the 4 cycles right after the compute phase, lowest byte first.
- R6: `out_valid` is 1 in exactly those 4 cycles and 0 at all other times, including every load and compute cycle.
- R7: Bytes offered with `in_valid` at 1 during the compute or send phase are dropped. They change neither the operand ports nor the next frame.
- R8: The cycle after the 4th result byte is already a load cycle. A byte offered then is byte 0 of the next frame, which gives a 27-cycle cadence for back-to-back frames.
- R9: When reset is asserted, `out_valid` and `core_start` go to 0, the operand ports go to 0, and any partly loaded frame is thrown away. The first 20 bytes accepted after reset form a complete new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_byte | input | 8 | Incoming frame byte |
| in_valid | input | 1 | Strobe marking `in_byte` as valid this cycle |
| out_byte | output | 8 | Result byte |
| out_valid | output | 1 | High when `out_byte` carries a result byte |
| core_start | output | 1 | One-cycle start pulse to the arithmetic core |
| op_a0 | output | 32 | Operand word a0 |
| op_a1 | output | 32 | Operand word a1 |
| op_b0 | output | 32 | Operand word b0 |
| op_b1 | output | 32 | Operand word b1 |
| op_c0 | output | 32 | Seed word c0 |
| core_result | input | 32 | Result from the core, valid by the end of the compute phase |

## Verification
The hardest case to reach from the ports is a strobed byte that arrives in the cycle the block goes back to loading, right after a stretch of dropped bytes. One cycle too early, and the byte is dropped or corrupts the frame. One cycle too late, and the frame shifts by a byte. The stimulus runs frames back to back and keeps `in_valid` high with junk bytes through every compute and send cycle. It also opens random gaps inside frames, so the boundary between dropped and accepted bytes is crossed in every transaction. The bench stands in for the arithmetic core with an integer function of the operand ports. Directed frames with a distinct value in each byte pin down the byte placement.

// File: rtl/fpdot_stream_pkg.sv
package fpdot_stream_pkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_EXEC = 2'd1,
    PH_SEND = 2'd2
  } phase_e;

  localparam int unsigned NUM_WORDS = 5;
endpackage

// File: rtl/fpdot_frame_loader.sv
module fpdot_frame_loader #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned FRAME_BYTES = 20,
  localparam int unsigned CNT_W      = $clog2(FRAME_BYTES),
  localparam int unsigned FRAME_W    = FRAME_BYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_byte,
  output logic [FRAME_W-1:0] frame_q,
  output logic               frame_done
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take;
  logic             at_last;

  assign take       = load_en & in_valid;
  assign at_last    = (cnt_q == LAST_IDX);
  assign frame_done = take & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (take) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // One capture slot per frame byte, enabled by the running count.
  for (genvar i = 0; i < FRAME_BYTES; i++) begin : g_slot
    logic wr_en;
    assign wr_en = take && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     frame_q[i*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en) frame_q[i*BYTE_W +: BYTE_W] <= in_byte;
    end
  end

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_IDX);

  assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(cnt_q));

  assert_idle_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(frame_q));
endmodule

// File: rtl/fpdot_phase_ctrl.sv
module fpdot_phase_ctrl
  import fpdot_stream_pkg::*;
#(
  parameter int unsigned EXEC_CYCLES = 3,
  parameter int unsigned OUT_BYTES   = 4,
  localparam int unsigned MAXV       = (EXEC_CYCLES > OUT_BYTES) ? EXEC_CYCLES : OUT_BYTES,
  localparam int unsigned CW         = $clog2(MAXV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  output logic load_en,
  output logic core_start,
  output logic capture,
  output logic send_en
);
  localparam logic [CW-1:0] EXEC_LAST = CW'(EXEC_CYCLES - 1);
  localparam logic [CW-1:0] SEND_LAST = CW'(OUT_BYTES - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] pc_q, pc_d;

  always_comb begin
    ph_d = ph_q;
    pc_d = pc_q;
    unique case (ph_q)
      PH_LOAD: begin
        if (frame_done) begin
          ph_d = PH_EXEC;
          pc_d = '0;
        end
      end
      PH_EXEC: begin
        if (pc_q == EXEC_LAST) begin
          ph_d = PH_SEND;
          pc_d = '0;
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
      PH_SEND: begin
        if (pc_q == SEND_LAST) begin
          ph_d = PH_LOAD;
          pc_d = '0;
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
      default: begin
        ph_d = PH_LOAD;
        pc_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_LOAD;
      pc_q <= '0;
    end else begin
      ph_q <= ph_d;
      pc_q <= pc_d;
    end
  end

  assign load_en    = (ph_q == PH_LOAD);
  assign core_start = (ph_q == PH_EXEC) && (pc_q == '0);
  assign capture    = (ph_q == PH_EXEC) && (pc_q == EXEC_LAST);
  assign send_en    = (ph_q == PH_SEND);

  assert_start_follows_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> core_start);

  if (EXEC_CYCLES > 1) begin : g_pulse_chk
    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);
  end

  assert_send_after_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_en) |-> $past(capture));

  assert_reload_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(send_en) |-> load_en);
endmodule

// File: rtl/fpdot_result_ser.sv
module fpdot_result_ser #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              send_en,
  input  logic [WORD_W-1:0] result_in,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid
);
  logic [WORD_W-1:0] sreg_q, sreg_d;

  always_comb begin
    sreg_d = sreg_q;
    if (capture)      sreg_d = result_in;
    else if (send_en) sreg_d = sreg_q >> BYTE_W;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign out_byte  = sreg_q[BYTE_W-1:0];
  assign out_valid = send_en;

  assert_low_byte_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_en) |-> out_byte == $past(result_in[BYTE_W-1:0]));
endmodule

// File: rtl/fpdot_byte_wrapper.sv
module fpdot_byte_wrapper
  import fpdot_stream_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned EXEC_CYCLES = 3,
  localparam int unsigned BPW         = WORD_W / BYTE_W,
  localparam int unsigned FRAME_BYTES = NUM_WORDS * BPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_valid,
  output logic              core_start,
  output logic [WORD_W-1:0] op_a0,
  output logic [WORD_W-1:0] op_a1,
  output logic [WORD_W-1:0] op_b0,
  output logic [WORD_W-1:0] op_b1,
  output logic [WORD_W-1:0] op_c0,
  input  logic [WORD_W-1:0] core_result
);
  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [FRAME_BYTES*BYTE_W-1:0] frame;
  logic load_en, frame_done, capture, send_en;

  fpdot_frame_loader #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES)) u_loader (
    .clk(clk), .rst_n(rst_int_n), .load_en(load_en), .in_valid(in_valid),
    .in_byte(in_byte), .frame_q(frame), .frame_done(frame_done)
  );

  fpdot_phase_ctrl #(.EXEC_CYCLES(EXEC_CYCLES), .OUT_BYTES(BPW)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .frame_done(frame_done), .load_en(load_en),
    .core_start(core_start), .capture(capture), .send_en(send_en)
  );

  fpdot_result_ser #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst_n(rst_int_n), .capture(capture), .send_en(send_en),
    .result_in(core_result), .out_byte(out_byte), .out_valid(out_valid)
  );

  assign op_a0 = frame[0*WORD_W +: WORD_W];
  assign op_a1 = frame[1*WORD_W +: WORD_W];
  assign op_b0 = frame[2*WORD_W +: WORD_W];
  assign op_b1 = frame[3*WORD_W +: WORD_W];
  assign op_c0 = frame[4*WORD_W +: WORD_W];

  assert_quiet_in_load_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    load_en |-> !out_valid && !core_start);

  assert_ops_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !load_en |=> $stable(op_c0) && $stable(op_a0));
endmodule

// File: tb/fpdot_byte_wrapper_test.sv
module fpdot_byte_wrapper_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  in_byte;
  logic        in_valid;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic        core_start;
  logic [31:0] op_a0, op_a1, op_b0, op_b1, op_c0;
  logic [31:0] core_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] w [5];

  always #4 clk = ~clk;

  function automatic logic [31:0] ref_core(input logic [31:0] a0, a1, b0, b1, c0);
    return (a0 * b0 + a1 * b1) ^ c0;
  endfunction

  // Stand-in for the arithmetic core, fed from the operand ports.
  assign core_result = ref_core(op_a0, op_a1, op_b0, op_b1, op_c0);

  fpdot_byte_wrapper uut (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid),
    .out_byte(out_byte), .out_valid(out_valid), .core_start(core_start),
    .op_a0(op_a0), .op_a1(op_a1), .op_b0(op_b0), .op_b1(op_b1), .op_c0(op_c0),
    .core_result(core_result)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_ops(input string req);
    chk(op_a0 == w[0], req, op_a0, w[0]);
    chk(op_a1 == w[1], req, op_a1, w[1]);
    chk(op_b0 == w[2], req, op_b0, w[2]);
    chk(op_b1 == w[3], req, op_b1, w[3]);
    chk(op_c0 == w[4], req, op_c0, w[4]);
  endtask

  // gap_pct: chance of an idle cycle before each byte; junk: strobed garbage while busy.
  task automatic run_frame(input int gap_pct, input bit junk);
    logic [31:0] exp;
    exp = ref_core(w[0], w[1], w[2], w[3], w[4]);
    for (int k = 0; k < 20; k++) begin
      while (($urandom % 100) < gap_pct) begin
        @(negedge clk);
        chk(!out_valid && !core_start, "R6 load quiet", {30'd0, out_valid, core_start}, 0);
        in_valid = 1'b0;
        in_byte  = 8'($urandom);   // R2: ignored without strobe
      end
      @(negedge clk);
      chk(!out_valid && !core_start, "R6 load quiet", {30'd0, out_valid, core_start}, 0);
      in_valid = 1'b1;
      in_byte  = w[k/4][(k%4)*8 +: 8];
    end
    for (int n = 0; n < 7; n++) begin
      @(negedge clk);
      chk(core_start == (n == 0), "R3 start pulse", {31'd0, core_start}, {31'd0, n == 0});
      chk(out_valid == (n >= 3), "R6 out_valid window", {31'd0, out_valid}, {31'd0, n >= 3});
      if (n == 0) check_ops("R1 operand assembly");
      if (n >= 3) chk(out_byte == exp[(n-3)*8 +: 8], "R5 R4 result byte",
                      {24'd0, out_byte}, {24'd0, exp[(n-3)*8 +: 8]});
      if (n == 6) check_ops("R7 operands unchanged by junk");
      in_valid = junk;
      in_byte  = 8'($urandom);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!out_valid && !core_start, "R9 reset outputs", {30'd0, out_valid, core_start}, 0);
    chk(op_c0 == 0 && op_a0 == 0, "R9 reset operands", op_c0 | op_a0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed: byte value equals its index (R1 placement)
    for (int i = 0; i < 5; i++)
      for (int b = 0; b < 4; b++) w[i][b*8 +: 8] = 8'(i*4 + b);
    run_frame(0, 0);
    // Directed: all zero, all ones, back to back with junk (R7, R8)
    for (int i = 0; i < 5; i++) w[i] = 32'd0;
    run_frame(0, 1);
    for (int i = 0; i < 5; i++) w[i] = 32'hFFFF_FFFF;
    run_frame(0, 1);

    // R9: abort a partial frame, then a full frame must be clean
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'hA5;
    end
    @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !core_start, "R9 mid-frame reset", {30'd0, out_valid, core_start}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) w[i] = 32'h1000_0001 * (i + 3);
    run_frame(0, 0);

    // Random frames: gaps (R2), junk while busy (R7), back to back (R8)
    for (int f = 0; f < 40; f++) begin
      for (int i = 0; i < 5; i++) w[i] = $urandom;
      run_frame((f % 3 == 0) ? 0 : 30, (f % 2) == 1);
    end

    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!out_valid, "R6 idle after last", {31'd0, out_valid}, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule